// File: doc/BRIEF.md
# Software-Managed Translation Buffer

This block is a fully associative address translation buffer of 32 slots that software fills and inspects through a small register file. Each slot maps a pair of adjacent virtual pages (even and odd) onto two physical frames, with a per-slot page size, an address-space tag and a global flag. Software stages a slot image in the staging registers (entry high, two entry-low words, page mask) and then issues one of four commands: write at the selected index, write at a rotating replacement slot, read back from the selected index, or probe for a slot that matches the staged entry high.

Alongside the command path, a purely combinational lookup port translates a virtual address using the address-space tag held in entry high. It returns the physical address and three fault flags: no slot matched, the selected half is not valid, or a store hit a half that is not writable. Commands are sequenced by a three-state machine: IDLE (accepts `cmd_valid`, goes to EXEC), EXEC (performs the slot write, the register load or the probe at the closing edge, always goes to FINISH) and FINISH (raises `cmd_done` for one cycle, always returns to IDLE).

Register select codes on `reg_sel`: 0 slot index, 1 replacement counter (read only), 2 wired boundary, 3 entry high, 4 entry-low even, 5 entry-low odd, 6 page mask. Command codes on `cmd_op`: 0 write at index, 1 write at replacement slot, 2 read at index, 3 probe.

Top module: `tlb_unit`

## Requirements
- R1: After reset the slot index, wired boundary and staging registers read 0, the replacement counter reads 31, no command is in flight, and every lookup reports a miss.
- R2: Write at index stores page mask, entry high, and both entry-low words into the slot named by index bits [4:0]; read at index loads the same four registers from that slot, so the read-back words equal the written ones (global bit excepted, see R8).
- R3: A command accepted in IDLE raises `cmd_done` exactly two cycles later for one cycle; `cmd_valid` seen while a command is in EXEC or FINISH is ignored.
- R4: A probe whose entry high matches a slot loads that slot number into index bits [4:0] and clears index bit 31; when several slots match, the lowest number wins.
- R5: A probe with no match sets index bit 31 and leaves index bits [4:0] unchanged.
- R6: The replacement counter starts at 31, steps down by one per clock, reloads to 31 on the clock after it reaches the wired value, and reloads to 31 whenever the wired register is written; it never reads below wired.
- R7: Write at replacement slot stores into the slot the counter names, which always lies between wired and 31; slots below wired are left untouched.
- R8: A slot matches only when its tag equals the entry-high tag, unless it is global; a slot becomes global only if entry-low bit 0 is set in both words when written, and reads back that shared global bit in both words.
- R9: Entry-high holds VPN2 in bits [31:13] and the tag in [7:0]; entry-low holds the frame number in [25:6], dirty in bit 2, valid in bit 1, global in bit 0. The lookup picks the odd half when virtual address bit 12+k is set (k = number of mask bits set) and forms the physical address from the frame number above that bit position and the virtual address below it.
- R10: Lookup raises exactly one of miss (no slot matches), invalid (selected half has valid 0) or modified (store to a valid half with dirty 0), or none.
- R11: Page-mask bits [24:13] exclude the corresponding low VPN2 bits from the match, so all addresses inside the enlarged page pair hit the same slot.
- R12: A lookup in the same cycle as a slot write sees the old slot contents; the new contents are visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Write strobe for the register file |
| reg_sel | input | 3 | Register select for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Selected register, combinational |
| cmd_valid | input | 1 | Command request, taken in IDLE |
| cmd_op | input | 2 | Command code |
| cmd_done | output | 1 | One-cycle completion pulse |
| lk_va | input | 32 | Lookup virtual address |
| lk_store | input | 1 | Lookup is a store |
| lk_miss | output | 1 | No slot matched |
| lk_invalid | output | 1 | Selected half not valid |
| lk_modified | output | 1 | Store to a non-writable half |
| lk_paddr | output | 32 | Translated physical address |

## Verification
The bench aims at the page-size arithmetic: an address whose VPN2 differs only in masked bits must hit while one differing just above the mask must miss, and the even/odd choice must move to bit 14 for 16 KiB pages; a design that ignored the mask or kept bit 12 would return the wrong frame. It walks the replacement counter through a reload at the wired boundary and then confirms a replacement write lands at 30 or 31, catching an off-by-one reload that would let a wired slot be overwritten. A slot with the global bit in only one word must still compare tags, and a probe miss must keep the old index bits while setting bit 31. A lookup during EXEC of a write must still return the old frame, which catches a write-through bypass.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int WORD_W   = 32;
    localparam int OFS_W    = 12;
    localparam int VPN2_LSB = 13;
    localparam int VPN2_W   = WORD_W - VPN2_LSB;
    localparam int ASID_W   = 8;
    localparam int PFN_LSB  = 6;
    localparam int PFN_W    = WORD_W - OFS_W;
    localparam int MASK_W   = 12;
    localparam int BIT_G    = 0;
    localparam int BIT_V    = 1;
    localparam int BIT_D    = 2;

    typedef enum logic [1:0] {
        OP_WR_IDX = 2'd0,
        OP_WR_RND = 2'd1,
        OP_RD_IDX = 2'd2,
        OP_PROBE  = 2'd3
    } tlb_op_e;

    typedef enum logic [2:0] {
        SEL_INDEX  = 3'd0,
        SEL_RANDOM = 3'd1,
        SEL_WIRED  = 3'd2,
        SEL_HI     = 3'd3,
        SEL_LO0    = 3'd4,
        SEL_LO1    = 3'd5,
        SEL_MASK   = 3'd6
    } tlb_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_EXEC   = 2'd1,
        ST_FINISH = 2'd2
    } tlb_state_e;

    typedef struct packed {
        logic [PFN_W-1:0] pfn;
        logic             dirty;
        logic             valid;
    } tlb_half_t;

    typedef struct packed {
        logic              used;
        logic              glob;
        logic [MASK_W-1:0] mask;
        logic [VPN2_W-1:0] vpn2;
        logic [ASID_W-1:0] asid;
        tlb_half_t         even;
        tlb_half_t         odd;
    } tlb_slot_t;

    function automatic logic slot_hit(input tlb_slot_t s,
                                      input logic [VPN2_W-1:0] vpn2,
                                      input logic [ASID_W-1:0] asid);
        logic [VPN2_W-1:0] care;
        care = ~{{(VPN2_W-MASK_W){1'b0}}, s.mask};
        return s.used && ((s.vpn2 & care) == (vpn2 & care)) &&
               (s.glob || (s.asid == asid));
    endfunction

endpackage

// File: rtl/tlb_random_ctr.sv
module tlb_random_ctr
    import tlb_pkg::*;
#(
    parameter int N_SLOTS = 32,
    parameter int IDX_W   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] wired,
    input  logic             wired_we,
    output logic [IDX_W-1:0] rnd
);

    localparam logic [IDX_W-1:0] TOP = IDX_W'(N_SLOTS - 1);

    logic [IDX_W-1:0] rnd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rnd_q <= TOP;
        else if (wired_we || (rnd_q <= wired))
            rnd_q <= TOP;
        else
            rnd_q <= rnd_q - 1'b1;
    end

    assign rnd = rnd_q;

    // R6
    rnd_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rnd_q >= wired);

    // R6
    rnd_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wired_we |=> (rnd_q == TOP));

endmodule

// File: rtl/tlb_slot_array.sv
module tlb_slot_array
    import tlb_pkg::*;
#(
    parameter int N_SLOTS = 32,
    parameter int IDX_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  tlb_slot_t         wslot,
    input  logic [IDX_W-1:0]  raddr,
    output tlb_slot_t         rslot,
    input  logic [VPN2_W-1:0] pr_vpn2,
    input  logic [ASID_W-1:0] pr_asid,
    output logic              pr_hit,
    output logic [IDX_W-1:0]  pr_idx,
    input  logic [VPN2_W-1:0] lk_vpn2,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              lk_hit,
    output tlb_slot_t         lk_slot
);

    tlb_slot_t          mem_q [N_SLOTS];
    logic [N_SLOTS-1:0] pr_m;
    logic [N_SLOTS-1:0] lk_m;
    logic [IDX_W-1:0]   lk_idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_SLOTS; i++)
                mem_q[i] <= '0;
        end else if (we) begin
            mem_q[waddr] <= wslot;
        end
    end

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_cmp
        assign pr_m[g] = slot_hit(mem_q[g], pr_vpn2, pr_asid);
        assign lk_m[g] = slot_hit(mem_q[g], lk_vpn2, lk_asid);
    end

    // lowest slot number wins on multiple matches
    always_comb begin
        pr_idx = '0;
        lk_idx = '0;
        for (int i = N_SLOTS - 1; i >= 0; i--) begin
            if (pr_m[i]) pr_idx = IDX_W'(i);
            if (lk_m[i]) lk_idx = IDX_W'(i);
        end
    end

    assign pr_hit  = |pr_m;
    assign lk_hit  = |lk_m;
    assign lk_slot = mem_q[lk_idx];
    assign rslot   = mem_q[raddr];

endmodule

// File: rtl/tlb_lookup.sv
module tlb_lookup
    import tlb_pkg::*;
(
    input  logic [WORD_W-1:0] va,
    input  logic              store,
    input  logic              hit,
    input  tlb_slot_t         slot,
    output logic              miss,
    output logic              invalid,
    output logic              modified,
    output logic [WORD_W-1:0] paddr
);

    logic [4:0]        span;
    logic [WORD_W-1:0] om;
    tlb_half_t         half;

    always_comb begin
        span     = 5'(OFS_W) + 5'($countones(slot.mask));
        half     = va[span] ? slot.odd : slot.even;
        om       = (WORD_W'(1) << span) - WORD_W'(1);
        paddr    = ({half.pfn, {OFS_W{1'b0}}} & ~om) | (va & om);
        miss     = !hit;
        invalid  = hit && !half.valid;
        modified = hit && half.valid && store && !half.dirty;
    end

endmodule

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
    import tlb_pkg::*;
#(
    parameter int N_SLOTS = 32,
    parameter int IDX_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_sel,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    output logic              cmd_done,
    input  logic [IDX_W-1:0]  rnd,
    output logic [IDX_W-1:0]  wired,
    output logic              wired_we,
    output logic              slot_we,
    output logic [IDX_W-1:0]  slot_waddr,
    output tlb_slot_t         slot_wdata,
    output logic [IDX_W-1:0]  slot_raddr,
    input  tlb_slot_t         slot_rdata,
    output logic [VPN2_W-1:0] hi_vpn2,
    output logic [ASID_W-1:0] hi_asid,
    input  logic              pr_hit,
    input  logic [IDX_W-1:0]  pr_idx
);

    tlb_state_e        state_q, state_d;
    tlb_op_e           op_q;
    logic              exec;
    logic [IDX_W-1:0]  idx_q;
    logic              fail_q;
    logic [IDX_W-1:0]  wired_q;
    logic [VPN2_W-1:0] vpn2_q;
    logic [ASID_W-1:0] asid_q;
    tlb_half_t         lo0_q, lo1_q;
    logic              lo0_g_q, lo1_g_q;
    logic [MASK_W-1:0] mask_q;
    logic              unused_bits;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= OP_WR_IDX;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && cmd_valid)
                op_q <= tlb_op_e'(cmd_op);
        end
    end

    always_comb begin
        state_d  = state_q;
        exec     = 1'b0;
        cmd_done = 1'b0;
        unique case (state_q)
            ST_IDLE:   if (cmd_valid) state_d = ST_EXEC;
            ST_EXEC:   begin exec = 1'b1; state_d = ST_FINISH; end
            ST_FINISH: begin cmd_done = 1'b1; state_d = ST_IDLE; end
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q   <= '0;
            fail_q  <= 1'b0;
            wired_q <= '0;
            vpn2_q  <= '0;
            asid_q  <= '0;
            lo0_q   <= '0;
            lo1_q   <= '0;
            lo0_g_q <= 1'b0;
            lo1_g_q <= 1'b0;
            mask_q  <= '0;
        end else begin
            if (reg_we) begin
                case (tlb_sel_e'(reg_sel))
                    SEL_INDEX: begin
                        fail_q <= reg_wdata[WORD_W-1];
                        idx_q  <= reg_wdata[IDX_W-1:0];
                    end
                    SEL_WIRED: wired_q <= reg_wdata[IDX_W-1:0];
                    SEL_HI: begin
                        vpn2_q <= reg_wdata[VPN2_LSB +: VPN2_W];
                        asid_q <= reg_wdata[ASID_W-1:0];
                    end
                    SEL_LO0: begin
                        lo0_q   <= '{pfn: reg_wdata[PFN_LSB +: PFN_W],
                                     dirty: reg_wdata[BIT_D], valid: reg_wdata[BIT_V]};
                        lo0_g_q <= reg_wdata[BIT_G];
                    end
                    SEL_LO1: begin
                        lo1_q   <= '{pfn: reg_wdata[PFN_LSB +: PFN_W],
                                     dirty: reg_wdata[BIT_D], valid: reg_wdata[BIT_V]};
                        lo1_g_q <= reg_wdata[BIT_G];
                    end
                    SEL_MASK: mask_q <= reg_wdata[VPN2_LSB +: MASK_W];
                    default: ;
                endcase
            end
            if (exec && op_q == OP_RD_IDX) begin
                mask_q  <= slot_rdata.mask;
                vpn2_q  <= slot_rdata.vpn2;
                asid_q  <= slot_rdata.asid;
                lo0_q   <= slot_rdata.even;
                lo1_q   <= slot_rdata.odd;
                lo0_g_q <= slot_rdata.glob;
                lo1_g_q <= slot_rdata.glob;
            end
            if (exec && op_q == OP_PROBE) begin
                if (pr_hit) begin
                    fail_q <= 1'b0;
                    idx_q  <= pr_idx;
                end else begin
                    fail_q <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        slot_wdata      = '0;
        slot_wdata.used = 1'b1;
        slot_wdata.glob = lo0_g_q & lo1_g_q;
        slot_wdata.mask = mask_q;
        slot_wdata.vpn2 = vpn2_q;
        slot_wdata.asid = asid_q;
        slot_wdata.even = lo0_q;
        slot_wdata.odd  = lo1_q;
    end

    assign slot_we    = exec && (op_q == OP_WR_IDX || op_q == OP_WR_RND);
    assign slot_waddr = (op_q == OP_WR_RND) ? rnd : idx_q;
    assign slot_raddr = idx_q;
    assign wired      = wired_q;
    assign wired_we   = reg_we && (tlb_sel_e'(reg_sel) == SEL_WIRED);
    assign hi_vpn2    = vpn2_q;
    assign hi_asid    = asid_q;

    always_comb begin
        reg_rdata = '0;
        case (tlb_sel_e'(reg_sel))
            SEL_INDEX: begin
                reg_rdata[WORD_W-1]  = fail_q;
                reg_rdata[IDX_W-1:0] = idx_q;
            end
            SEL_RANDOM: reg_rdata[IDX_W-1:0] = rnd;
            SEL_WIRED:  reg_rdata[IDX_W-1:0] = wired_q;
            SEL_HI: begin
                reg_rdata[VPN2_LSB +: VPN2_W] = vpn2_q;
                reg_rdata[ASID_W-1:0]         = asid_q;
            end
            SEL_LO0: begin
                reg_rdata[PFN_LSB +: PFN_W] = lo0_q.pfn;
                reg_rdata[BIT_D]            = lo0_q.dirty;
                reg_rdata[BIT_V]            = lo0_q.valid;
                reg_rdata[BIT_G]            = lo0_g_q;
            end
            SEL_LO1: begin
                reg_rdata[PFN_LSB +: PFN_W] = lo1_q.pfn;
                reg_rdata[BIT_D]            = lo1_q.dirty;
                reg_rdata[BIT_V]            = lo1_q.valid;
                reg_rdata[BIT_G]            = lo1_g_q;
            end
            SEL_MASK: reg_rdata[VPN2_LSB +: MASK_W] = mask_q;
            default: ;
        endcase
    end

    assign unused_bits = ^{reg_wdata, slot_rdata.used};

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> !cmd_done);

    // R3
    cmd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && cmd_valid) |-> ##2 cmd_done);

    // R7
    rnd_pool_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && op_q == OP_WR_RND) |-> (slot_waddr >= wired_q));

    // R5
    probe_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && op_q == OP_PROBE && !pr_hit) |=> (fail_q && $stable(idx_q)));

endmodule

// File: rtl/tlb_unit.sv
module tlb_unit
    import tlb_pkg::*;
#(
    parameter int N_SLOTS = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [2:0]  reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        cmd_valid,
    input  logic [1:0]  cmd_op,
    output logic        cmd_done,
    input  logic [31:0] lk_va,
    input  logic        lk_store,
    output logic        lk_miss,
    output logic        lk_invalid,
    output logic        lk_modified,
    output logic [31:0] lk_paddr
);

    localparam int IDX_W = $clog2(N_SLOTS);

    logic [IDX_W-1:0]  rnd, wired, slot_waddr, slot_raddr, pr_idx;
    logic              wired_we, slot_we, pr_hit, lk_hit;
    tlb_slot_t         slot_wdata, slot_rdata, lk_slot;
    logic [VPN2_W-1:0] hi_vpn2;
    logic [ASID_W-1:0] hi_asid;

    tlb_random_ctr #(.N_SLOTS(N_SLOTS), .IDX_W(IDX_W)) u_rnd (
        .clk      (clk),
        .rst_n    (rst_n),
        .wired    (wired),
        .wired_we (wired_we),
        .rnd      (rnd)
    );

    tlb_ctrl #(.N_SLOTS(N_SLOTS), .IDX_W(IDX_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_sel    (reg_sel),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .cmd_done   (cmd_done),
        .rnd        (rnd),
        .wired      (wired),
        .wired_we   (wired_we),
        .slot_we    (slot_we),
        .slot_waddr (slot_waddr),
        .slot_wdata (slot_wdata),
        .slot_raddr (slot_raddr),
        .slot_rdata (slot_rdata),
        .hi_vpn2    (hi_vpn2),
        .hi_asid    (hi_asid),
        .pr_hit     (pr_hit),
        .pr_idx     (pr_idx)
    );

    tlb_slot_array #(.N_SLOTS(N_SLOTS), .IDX_W(IDX_W)) u_arr (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (slot_we),
        .waddr   (slot_waddr),
        .wslot   (slot_wdata),
        .raddr   (slot_raddr),
        .rslot   (slot_rdata),
        .pr_vpn2 (hi_vpn2),
        .pr_asid (hi_asid),
        .pr_hit  (pr_hit),
        .pr_idx  (pr_idx),
        .lk_vpn2 (lk_va[VPN2_LSB +: VPN2_W]),
        .lk_asid (hi_asid),
        .lk_hit  (lk_hit),
        .lk_slot (lk_slot)
    );

    tlb_lookup u_lk (
        .va       (lk_va),
        .store    (lk_store),
        .hit      (lk_hit),
        .slot     (lk_slot),
        .miss     (lk_miss),
        .invalid  (lk_invalid),
        .modified (lk_modified),
        .paddr    (lk_paddr)
    );

    // R10
    lk_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lk_miss, lk_invalid, lk_modified}));

endmodule

// File: tb/tlb_unit_tb_top.sv
`timescale 1ns/1ps
module tlb_unit_tb_top;

    localparam logic [2:0] S_IDX = 3'd0, S_RND = 3'd1, S_WIRED = 3'd2, S_HI = 3'd3,
                           S_LO0 = 3'd4, S_LO1 = 3'd5, S_MASK = 3'd6;
    localparam logic [1:0] C_WI = 2'd0, C_WR = 2'd1, C_RI = 2'd2, C_PR = 2'd3;

    // {va, store, miss, invalid, modified, paddr}
    localparam logic [67:0] VEC [9] = '{
        {32'h00020123, 1'b0, 3'b000, 32'h00100123},
        {32'h00021ABC, 1'b1, 3'b001, 32'h00200ABC},
        {32'h00021ABC, 1'b0, 3'b000, 32'h00200ABC},
        {32'h00080010, 1'b0, 3'b010, 32'h00300010},
        {32'h00081FF0, 1'b1, 3'b000, 32'h00400FF0},
        {32'h00022000, 1'b0, 3'b100, 32'h00000000},
        {32'h00205678, 1'b0, 3'b000, 32'h02001678},
        {32'h00203000, 1'b0, 3'b000, 32'h01003000},
        {32'h00208000, 1'b0, 3'b100, 32'h00000000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic        cmd_done;
    logic [31:0] lk_va = '0;
    logic        lk_store = 1'b0;
    logic        lk_miss, lk_invalid, lk_modified;
    logic [31:0] lk_paddr;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    tlb_unit dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_done(cmd_done), .lk_va(lk_va), .lk_store(lk_store),
        .lk_miss(lk_miss), .lk_invalid(lk_invalid), .lk_modified(lk_modified),
        .lk_paddr(lk_paddr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = s; reg_wdata = d;
        @(posedge clk);
        #1 reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] s, output logic [31:0] v);
        @(negedge clk);
        reg_sel = s;
        #1 v = reg_rdata;
    endtask

    task automatic cmd(input logic [1:0] op);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op;
        @(negedge clk);
        cmd_valid = 1'b0;
        @(negedge clk);
        #1 chk("R3 done pulse", {31'd0, cmd_done}, 32'd1);
    endtask

    task automatic prog(input logic [4:0] slot, input logic [31:0] hi,
                        input logic [31:0] l0, input logic [31:0] l1, input logic [31:0] pm);
        wr(S_HI, hi); wr(S_LO0, l0); wr(S_LO1, l1); wr(S_MASK, pm);
        wr(S_IDX, {27'd0, slot});
        cmd(C_WI);
    endtask

    task automatic look(input logic [31:0] va, input logic st);
        @(negedge clk);
        lk_va = va; lk_store = st;
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL R3 watchdog actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        // R1: reset state
        reg_sel = S_RND;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1 chk("R1 random at reset", reg_rdata, 32'd31);
        chk("R1 no done", {31'd0, cmd_done}, 32'd0);
        chk("R1 empty lookup miss", {31'd0, lk_miss}, 32'd1);
        rd(S_IDX, v);   chk("R1 index", v, 32'd0);
        rd(S_WIRED, v); chk("R1 wired", v, 32'd0);
        rd(S_HI, v);    chk("R1 entry high", v, 32'd0);

        // R6: replacement counter sequence with wired = 28
        wr(S_WIRED, 32'd28);
        rd(S_RND, v); chk("R6 reload on wired write", v, 32'd31);
        rd(S_RND, v); chk("R6 step", v, 32'd30);
        rd(S_RND, v); chk("R6 step", v, 32'd29);
        rd(S_RND, v); chk("R6 at wired", v, 32'd28);
        rd(S_RND, v); chk("R6 reload below wired", v, 32'd31);
        wr(S_WIRED, 32'd0);

        prog(5'd3,  32'h00020005, 32'h00004006, 32'h00008002, 32'h0);
        prog(5'd7,  32'h00080009, 32'h0000C001, 32'h00010007, 32'h0);
        prog(5'd12, 32'h00200005, 32'h00040006, 32'h00080006, 32'h00006000);
        prog(5'd20, 32'h00600009, 32'h00014003, 32'h00018002, 32'h0);
        wr(S_HI, 32'h00000005);

        // R9 R10 R11: lookup table
        for (int i = 0; i < 9; i++) begin
            look(VEC[i][67:36], VEC[i][35]);
            chk($sformatf("R10 flags vec%0d", i),
                {29'd0, lk_miss, lk_invalid, lk_modified}, {29'd0, VEC[i][34:32]});
            if (!VEC[i][34])
                chk($sformatf("R9 R11 paddr vec%0d", i), lk_paddr, VEC[i][31:0]);
        end

        // R8: tag compare and global
        wr(S_HI, 32'h00000006);
        look(32'h00020123, 1'b0); chk("R8 tag mismatch miss", {31'd0, lk_miss}, 32'd1);
        look(32'h00081FF0, 1'b0); chk("R8 global ignores tag", lk_paddr, 32'h00400FF0);
        chk("R8 global hit", {31'd0, lk_miss}, 32'd0);
        wr(S_HI, 32'h00000005);
        look(32'h00600000, 1'b0); chk("R8 half-global not global", {31'd0, lk_miss}, 32'd1);

        // R2: read-back
        wr(S_IDX, 32'd12); cmd(C_RI);
        rd(S_HI, v);   chk("R2 hi slot12", v, 32'h00200005);
        rd(S_LO0, v);  chk("R2 lo0 slot12", v, 32'h00040006);
        rd(S_LO1, v);  chk("R2 lo1 slot12", v, 32'h00080006);
        rd(S_MASK, v); chk("R2 mask slot12", v, 32'h00006000);
        wr(S_IDX, 32'd7); cmd(C_RI);
        rd(S_HI, v);   chk("R2 hi slot7", v, 32'h00080009);
        rd(S_LO0, v);  chk("R8 lo0 slot7 global", v, 32'h0000C001);
        rd(S_LO1, v);  chk("R8 lo1 slot7 global", v, 32'h00010007);
        wr(S_IDX, 32'd20); cmd(C_RI);
        rd(S_LO0, v);  chk("R8 lo0 slot20 global dropped", v, 32'h00014002);

        // R4 R5: probe
        wr(S_HI, 32'h00020005); cmd(C_PR);
        rd(S_IDX, v); chk("R4 probe slot3", v, 32'd3);
        wr(S_HI, 32'h00204005); cmd(C_PR);
        rd(S_IDX, v); chk("R4 R11 probe masked slot12", v, 32'd12);
        wr(S_HI, 32'h00022005); cmd(C_PR);
        rd(S_IDX, v); chk("R5 probe miss", v, 32'h8000000C);
        wr(S_HI, 32'h00080005); cmd(C_PR);
        rd(S_IDX, v); chk("R4 probe global slot7", v, 32'd7);

        // R12 R3: lookup during write, busy command ignored
        wr(S_HI, 32'h00020005); wr(S_LO0, 32'h00004446);
        wr(S_LO1, 32'h00008002); wr(S_MASK, 32'h0); wr(S_IDX, 32'd3);
        @(negedge clk);
        lk_va = 32'h00020123; lk_store = 1'b0;
        cmd_valid = 1'b1; cmd_op = C_WI;
        @(negedge clk);
        cmd_op = C_PR;
        #1 chk("R12 old frame during write", lk_paddr, 32'h00100123);
        chk("R3 no done in exec", {31'd0, cmd_done}, 32'd0);
        @(negedge clk);
        cmd_valid = 1'b0;
        #1 chk("R3 done after two cycles", {31'd0, cmd_done}, 32'd1);
        chk("R12 new frame after write", lk_paddr, 32'h00111123);
        @(negedge clk); #1 chk("R3 busy request ignored", {31'd0, cmd_done}, 32'd0);
        @(negedge clk); #1 chk("R3 busy request ignored", {31'd0, cmd_done}, 32'd0);

        // R7: replacement write confined to wired..31
        wr(S_WIRED, 32'd30);
        wr(S_HI, 32'h00400005); wr(S_LO0, 32'h0001C002);
        wr(S_LO1, 32'h0); wr(S_MASK, 32'h0);
        cmd(C_WR);
        cmd(C_PR);
        rd(S_IDX, v);
        chk("R7 random slot in pool", {31'd0, (v == 32'd30 || v == 32'd31)}, 32'd1);
        look(32'h00400000, 1'b0); chk("R7 random slot translates", lk_paddr, 32'h00700000);
        look(32'h00020123, 1'b0); chk("R7 wired slot untouched", lk_paddr, 32'h00111123);
        chk("R7 wired slot still hits", {31'd0, lk_miss}, 32'd0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule